// File: doc/BRIEF.md
# Time-of-Day Alarm Comparator with Repeat Selection

This block holds four alarm registers and compares them with a running calendar time: seconds, minutes, hours and day of the month, all in BCD. The calendar comes from outside the block. A one-cycle strobe marks each new second. On the strobe, the block compares the alarm fields that are in use with the current time. If they agree, it raises a single-cycle interrupt pulse.

Bit 7 of each alarm register is a "don't care" flag for that field. The flags choose how often the alarm repeats. With no flags set, it fires once a month. With the day flag set, it fires once a day. With the day and hour flags set, it fires once an hour. With the day, hour and minute flags set, it fires once a minute. Every other flag pattern makes it fire once a second.

A register write is range-checked. A value that is not valid BCD for its field is dropped, and the register keeps its previous contents.

Top module: `rtc_alarm_match`

## Requirements
- R1: Reset clears all four alarm registers to 0x00 and holds `irq` low. After reset, a strobe with the current time all 0x00 yields a pulse, and a strobe at second 0x01 does not.
- R2: `wr_sel` selects the register that `wr_data` goes to: 0 = seconds, 1 = minutes, 2 = hours, 3 = day of month. A write takes effect at the clock edge where `wr_en` is high.
- R3: For seconds and minutes, bits 6:0 are checked as BCD. Each nibble must be 0–9 and the value must be 0–59. Otherwise the write is ignored and the old value is kept.
- R4: For hours, bits 5:0 are checked as BCD in the range 0–23. A failing write is ignored.
- R5: For day of month, bits 5:0 are checked as BCD in the range 1–31. A failing write is ignored.
- R6: With no repeat flags set (bit 7 of all four registers clear), a pulse needs day, hour, minute and second all to match. Seconds and minutes compare bits 6:0; hours and day compare bits 5:0.
- R7: With only the day flag set, a pulse needs hour, minute and second to match. The day is ignored.
- R8: With the day and hour flags set and the others clear, a pulse needs minute and second to match.
- R9: With the day, hour and minute flags set and the seconds flag clear, a pulse needs only the second to match.
- R10: With all four flags set, or with any flag pattern not listed in R6–R9, every strobe yields a pulse.
- R11: `irq` is high for exactly the one cycle after a clock edge at which `tick` was high and the compare matched. Without a strobe, `irq` stays low whatever the time inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select (0 sec, 1 min, 2 hour, 3 day) |
| wr_data | input | 8 | Write value; bit 7 is the repeat flag |
| tick | input | 1 | One-cycle strobe at each new second |
| cur_sec | input | 8 | Current seconds, BCD |
| cur_min | input | 8 | Current minutes, BCD |
| cur_hour | input | 8 | Current hours, BCD |
| cur_day | input | 8 | Current day of month, BCD |
| irq | output | 1 | Alarm interrupt pulse |

## Verification
A strobe sampled at one rising edge shows up as `irq` right after that edge and lasts one cycle. A write likewise changes the compare from the next edge on. The bench therefore drives every input on the falling edge and reads `irq` on the following falling edge, so there is exactly one register between stimulus and check.

A behavioural model in the bench works out the expected `irq` for every cycle from the same sampled inputs, and the bench compares it with the design on every falling edge. In addition, each directed strobe checks `irq` against a value worked out by hand.

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match #(
  parameter int SEC_MAX  = 59,
  parameter int HOUR_MAX = 23,
  parameter int DAY_MIN  = 1,
  parameter int DAY_MAX  = 31
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_sel,
  input  logic [7:0] wr_data,
  input  logic       tick,
  input  logic [7:0] cur_sec,
  input  logic [7:0] cur_min,
  input  logic [7:0] cur_hour,
  input  logic [7:0] cur_day,
  output logic       irq
);

  localparam logic [1:0] SEL_SEC  = 2'd0;
  localparam logic [1:0] SEL_MIN  = 2'd1;
  localparam logic [1:0] SEL_HOUR = 2'd2;
  localparam logic [1:0] SEL_DAY  = 2'd3;

  logic [7:0] a_sec, a_min, a_hour, a_day;
  logic       wr_ok;
  logic [3:0] flags;
  logic       use_day, use_hour, use_min, use_sec;
  logic       hit;

  function automatic int bcd_val(input logic [6:0] b);
    return int'(b[6:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic logic bcd_in(input logic [6:0] b, input int lo, input int hi);
    return (b[3:0] <= 4'd9) && (bcd_val(b) >= lo) && (bcd_val(b) <= hi);
  endfunction

  always_comb begin
    case (wr_sel)
      SEL_SEC, SEL_MIN: wr_ok = bcd_in(wr_data[6:0], 0, SEC_MAX);
      SEL_HOUR:         wr_ok = bcd_in({1'b0, wr_data[5:0]}, 0, HOUR_MAX);
      default:          wr_ok = bcd_in({1'b0, wr_data[5:0]}, DAY_MIN, DAY_MAX);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_sec  <= '0;
      a_min  <= '0;
      a_hour <= '0;
      a_day  <= '0;
    end else if (wr_en && wr_ok) begin
      case (wr_sel)
        SEL_SEC:  a_sec  <= wr_data;
        SEL_MIN:  a_min  <= wr_data;
        SEL_HOUR: a_hour <= wr_data;
        default:  a_day  <= wr_data;
      endcase
    end
  end

  assign flags    = {a_day[7], a_hour[7], a_min[7], a_sec[7]};
  assign use_day  = (flags == 4'b0000);
  assign use_hour = use_day  | (flags == 4'b1000);
  assign use_min  = use_hour | (flags == 4'b1100);
  assign use_sec  = use_min  | (flags == 4'b1110);

  assign hit = (!use_sec  || a_sec[6:0]  == cur_sec[6:0])
            && (!use_min  || a_min[6:0]  == cur_min[6:0])
            && (!use_hour || a_hour[5:0] == cur_hour[5:0])
            && (!use_day  || a_day[5:0]  == cur_day[5:0]);

  always_ff @(posedge clk) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= tick & hit;
  end

endmodule

// File: rtl/rtc_alarm_match_chk.sv
module rtc_alarm_match_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       wr_en,
  input logic       irq,
  input logic [7:0] a_sec,
  input logic [7:0] a_min,
  input logic [7:0] a_hour,
  input logic [7:0] a_day
);

  function automatic int dv(input logic [6:0] b);
    return int'(b[6:4]) * 10 + int'(b[3:0]);
  endfunction

  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> !irq); // R1
  AST_SEC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (a_sec[3:0] <= 4'd9) && (dv(a_sec[6:0]) <= 59) && (a_min[3:0] <= 4'd9) && (dv(a_min[6:0]) <= 59)); // R3
  AST_HOUR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (a_hour[3:0] <= 4'd9) && (dv({1'b0, a_hour[5:0]}) <= 23)); // R4
  AST_DAY_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (a_day[3:0] <= 4'd9) && (dv({1'b0, a_day[5:0]}) <= 31)); // R5
  AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable({a_sec, a_min, a_hour, a_day})); // R2
  AST_EVERY_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && a_sec[7] && a_min[7] && a_hour[7] && a_day[7]) |=> irq); // R10
  AST_PULSE_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(tick)); // R11

endmodule

bind rtc_alarm_match rtc_alarm_match_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .irq(irq),
  .a_sec(a_sec), .a_min(a_min), .a_hour(a_hour), .a_day(a_day)
);

// File: tb/rtc_alarm_match_tb.sv
module rtc_alarm_match_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = '0;
  logic [7:0] wr_data = '0;
  logic       tick = 1'b0;
  logic [7:0] cur_sec = '0, cur_min = '0, cur_hour = '0, cur_day = '0;
  logic       irq;

  int total = 0;
  int bad = 0;
  string phase = "R1";
  int regs [4];
  logic exp_irq = 1'b0;
  bit model_on = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_alarm_match u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .tick(tick), .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour),
    .cur_day(cur_day), .irq(irq)
  );

  function automatic int num(input int v);
    return ((v >> 4) & 7) * 10 + (v & 15);
  endfunction

  function automatic bit legal(input int sel, input int v);
    int f;
    f = (sel < 2) ? (v & 8'h7f) : (v & 8'h3f);
    if ((f & 15) > 9) return 0;
    if (sel < 2) return num(f) <= 59;
    if (sel == 2) return num(f) <= 23;
    return num(f) >= 1 && num(f) <= 31;
  endfunction

  function automatic bit expect_hit();
    bit fd, fh, fm, fs;
    int need;
    fs = regs[0][7]; fm = regs[1][7]; fh = regs[2][7]; fd = regs[3][7];
    // need = number of fields compared, counted from seconds upward
    if (!fd && !fh && !fm && !fs)      need = 4;
    else if (fd && !fh && !fm && !fs)  need = 3;
    else if (fd && fh && !fm && !fs)   need = 2;
    else if (fd && fh && fm && !fs)    need = 1;
    else                               need = 0;
    if (need >= 1 && num(regs[0] & 8'h7f) != num(cur_sec & 8'h7f)) return 0;
    if (need >= 2 && num(regs[1] & 8'h7f) != num(cur_min & 8'h7f)) return 0;
    if (need >= 3 && num(regs[2] & 8'h3f) != num(cur_hour & 8'h3f)) return 0;
    if (need >= 4 && num(regs[3] & 8'h3f) != num(cur_day & 8'h3f)) return 0;
    return 1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      exp_irq <= 1'b0;
      for (int i = 0; i < 4; i++) regs[i] <= 0;
    end else begin
      exp_irq <= tick && expect_hit();
      if (wr_en && legal(int'(wr_sel), int'(wr_data))) regs[wr_sel] <= int'(wr_data);
    end
  end

  always @(negedge clk) begin
    if (model_on) begin
      total++;
      if (irq !== exp_irq) begin
        bad++;
        $display("FAIL %s model compare: irq=%b expected=%b at %0t", phase, irq, exp_irq, $time);
      end
    end
  end

  task automatic check(input string req, input logic actual, input logic expected);
    total++;
    if (actual !== expected) begin
      bad++;
      $display("FAIL %s: irq=%b expected=%b at %0t", req, actual, expected, $time);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    wr_sel = s; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic strobe(input string req, input logic [7:0] s, input logic [7:0] m,
                        input logic [7:0] h, input logic [7:0] d, input logic expected);
    cur_sec = s; cur_min = m; cur_hour = h; cur_day = d; tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    check(req, irq, expected);
    @(negedge clk);
    check({req, " pulse width R11"}, irq, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 irq in reset", irq, 1'b0);
    rst_n = 1'b1;
    model_on = 1;
    @(negedge clk);
    phase = "R1";
    strobe("R1 zero regs match", 8'h00, 8'h00, 8'h00, 8'h00, 1'b1);
    strobe("R1 zero regs miss", 8'h01, 8'h00, 8'h00, 8'h00, 1'b0);

    phase = "R6";
    wr(2'd0, 8'h30); wr(2'd1, 8'h15); wr(2'd2, 8'h12); wr(2'd3, 8'h25);
    strobe("R2 R6 monthly full match", 8'h30, 8'h15, 8'h12, 8'h25, 1'b1);
    strobe("R6 day differs", 8'h30, 8'h15, 8'h12, 8'h24, 1'b0);
    strobe("R6 second differs", 8'h31, 8'h15, 8'h12, 8'h25, 1'b0);

    phase = "R11";
    cur_sec = 8'h30; cur_min = 8'h15; cur_hour = 8'h12; cur_day = 8'h25;
    repeat (3) @(negedge clk);
    check("R11 matching time without tick", irq, 1'b0);

    phase = "R3";
    wr(2'd0, 8'h60); wr(2'd0, 8'h5a); wr(2'd1, 8'h7f);
    strobe("R3 bad sec/min writes ignored", 8'h30, 8'h15, 8'h12, 8'h25, 1'b1);
    wr(2'd1, 8'h59);
    strobe("R3 minute 59 accepted", 8'h30, 8'h59, 8'h12, 8'h25, 1'b1);

    phase = "R4";
    wr(2'd2, 8'h24); wr(2'd2, 8'h1b);
    strobe("R4 bad hour ignored", 8'h30, 8'h59, 8'h12, 8'h25, 1'b1);
    wr(2'd2, 8'h23);
    strobe("R4 hour 23 accepted", 8'h30, 8'h59, 8'h23, 8'h25, 1'b1);

    phase = "R5";
    wr(2'd3, 8'h00); wr(2'd3, 8'h32);
    strobe("R5 bad day ignored", 8'h30, 8'h59, 8'h23, 8'h25, 1'b1);
    wr(2'd3, 8'h31);
    strobe("R5 day 31 accepted", 8'h30, 8'h59, 8'h23, 8'h31, 1'b1);

    phase = "R7";
    wr(2'd3, 8'hb1);
    strobe("R7 daily other day", 8'h30, 8'h59, 8'h23, 8'h03, 1'b1);
    strobe("R7 daily hour differs", 8'h30, 8'h59, 8'h22, 8'h03, 1'b0);

    phase = "R8";
    wr(2'd2, 8'ha3);
    strobe("R8 hourly other hour", 8'h30, 8'h59, 8'h05, 8'h03, 1'b1);
    strobe("R8 hourly minute differs", 8'h30, 8'h58, 8'h05, 8'h03, 1'b0);

    phase = "R9";
    wr(2'd1, 8'hd9);
    strobe("R9 minutely other minute", 8'h30, 8'h10, 8'h05, 8'h03, 1'b1);
    strobe("R9 minutely second differs", 8'h29, 8'h10, 8'h05, 8'h03, 1'b0);

    phase = "R10";
    wr(2'd0, 8'hb0);
    strobe("R10 all flags any time", 8'h07, 8'h44, 8'h19, 8'h11, 1'b1);
    wr(2'd3, 8'h25);
    strobe("R10 non-contiguous flags", 8'h01, 8'h02, 8'h03, 8'h04, 1'b1);
    wr(2'd0, 8'h30); wr(2'd1, 8'h15); wr(2'd2, 8'h92);
    strobe("R10 hour-only flag", 8'h55, 8'h33, 8'h01, 8'h09, 1'b1);

    phase = "R1";
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    strobe("R1 regs cleared by reset", 8'h00, 8'h00, 8'h00, 8'h00, 1'b1);

    model_on = 0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule